// File: doc/BRIEF.md
# Hot-Plug Bus Speed Mode Selector

This block picks the fastest bus mode that every occupied hot-plug slot on a bus segment can handle. Each slot supplies an occupied flag, a 66 MHz strap, and two capability bits that together carry a three-level capability pin. The first capability bit tells a conventional-only card apart from a PCI-X card. The second bit tells a 66 MHz PCI-X card apart from a 133 MHz one.

After reset the bus holds the 33 MHz conventional mode for a fixed scan window. When the window ends, the block compares the computed mode with the current one. Whenever the two differ, it registers the new mode and raises a one-cycle bus reset request in the same cycle. It keeps re-evaluating afterwards, so inserting a slower card brings the mode down.

A hot-plug slot count of zero turns the block off. No scan takes place and the mode is not changed.

Top module: `hp_speed_sel`

## Requirements
- R1: While rst_n is low, bus_mode is 2'b00 (33 MHz PCI) and bus_rst_req is 0. With slot_cnt nonzero, scanning is 1.
- R2: For the first SCAN_CYC rising edges after reset with slot_cnt nonzero, scanning stays 1, bus_mode stays 2'b00 and bus_rst_req stays 0.
- R3: Each slot's capability is decoded as follows. If cap_x=0, the card is conventional and runs at 66 MHz PCI (2'b01) when m66_en=1, otherwise at 33 MHz PCI (2'b00). If cap_x=1, the card runs at 133 MHz PCI-X (2'b11) when cap_hi=1, otherwise at 66 MHz PCI-X (2'b10).
- R4: After the scan, the mode is the minimum of seg_max and the decoded modes of the considered slots. The order is 00 < 01 < 10 < 11.
- R5: A slot is considered only if slot_closed is 1 and its index is below slot_cnt. When no slot is considered, the mode equals seg_max.
- R6: bus_rst_req is high for exactly the cycle that follows a rising edge at which bus_mode took a new value. It is never high when bus_mode did not change.
- R7: While slot_cnt is 0, scanning is 0, the scan does not advance, bus_mode keeps its value and bus_rst_req stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_cnt | input | 3 | Number of hot-plug slots; 0 disables the block |
| slot_closed | input | NSLOT | Slot occupied and closed, one bit per slot |
| m66_en | input | NSLOT | 66 MHz strap of each slot |
| cap_x | input | NSLOT | Capability pin not grounded (PCI-X capable) |
| cap_hi | input | NSLOT | Capability pin high (133 MHz capable) |
| seg_max | input | 2 | Fastest mode the segment allows |
| bus_mode | output | 2 | Current bus mode (00 33 PCI, 01 66 PCI, 10 66 PCI-X, 11 133 PCI-X) |
| bus_rst_req | output | 1 | One-cycle bus reset request on a mode change |
| scanning | output | 1 | Post-reset scan window is active |

## Verification
The end of the scan window and the first upgrade decision fall in neighbouring edges. To provoke this, the bench changes a slot's capability just before the last scan edge, then checks that the first post-scan decision uses the new value and produces a single request. A second collision puts slot_cnt at zero in the same cycle that a mode difference appears. In that case the expected result is that the mode does not move and no request is raised. Random stimulus mixes slot counts, occupancy and segment limits, and the bench checks every cycle against a bench-side model.

// File: rtl/hp_speed_sel.sv
module hp_speed_sel #(
  parameter int NSLOT    = 4,
  parameter int SCAN_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       slot_cnt,
  input  logic [NSLOT-1:0] slot_closed,
  input  logic [NSLOT-1:0] m66_en,
  input  logic [NSLOT-1:0] cap_x,
  input  logic [NSLOT-1:0] cap_hi,
  input  logic [1:0]       seg_max,
  output logic [1:0]       bus_mode,
  output logic             bus_rst_req,
  output logic             scanning
);
  localparam int CW = (SCAN_CYC > 1) ? $clog2(SCAN_CYC) : 1;

  logic [CW-1:0] scan_cnt;
  logic          in_run;
  logic          active;
  logic [1:0]    chain [NSLOT+1];
  logic [1:0]    target;

  assign active   = (slot_cnt != 3'd0);
  assign scanning = active && !in_run;
  assign chain[0] = seg_max;
  assign target   = chain[NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic [1:0] smode;
    logic       used;
    assign smode = cap_x[i] ? {1'b1, cap_hi[i]} : {1'b0, m66_en[i]};
    assign used  = slot_closed[i] && (i < int'(slot_cnt));
    assign chain[i+1] = (used && (smode < chain[i])) ? smode : chain[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_cnt    <= '0;
      in_run      <= 1'b0;
      bus_mode    <= 2'b00;
      bus_rst_req <= 1'b0;
    end else begin
      bus_rst_req <= 1'b0;
      if (active) begin
        if (!in_run) begin
          if (scan_cnt == CW'(SCAN_CYC - 1)) in_run <= 1'b1;
          else scan_cnt <= scan_cnt + 1'b1;
        end else if (target != bus_mode) begin
          bus_mode    <= target;
          bus_rst_req <= 1'b1;
        end
      end
    end
  end
endmodule

module hp_speed_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] slot_cnt,
  input logic [1:0] seg_max,
  input logic [1:0] bus_mode,
  input logic       bus_rst_req,
  input logic       scanning
);
  assert_req_means_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_req |-> (bus_mode != $past(bus_mode)));
  assert_change_means_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode != $past(bus_mode)) |-> bus_rst_req);
  assert_scan_slow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    scanning |-> (bus_mode == 2'b00 && !bus_rst_req));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_cnt == 3'd0) |=> ($stable(bus_mode) && !bus_rst_req));
  assert_within_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_req |-> (bus_mode <= $past(seg_max)));
endmodule

bind hp_speed_sel hp_speed_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slot_cnt(slot_cnt), .seg_max(seg_max),
  .bus_mode(bus_mode), .bus_rst_req(bus_rst_req), .scanning(scanning)
);

// File: tb/hp_speed_sel_test.sv
module hp_speed_sel_test;
  localparam int NSLOT = 4;
  localparam int SCAN_CYC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] slot_cnt = 3'd4;
  logic [NSLOT-1:0] slot_closed = '1, m66_en = '1, cap_x = '1, cap_hi = '1;
  logic [1:0] seg_max = 2'b11;
  logic [1:0] bus_mode;
  logic bus_rst_req, scanning;

  int n_chk = 0, n_bad = 0;
  int left;
  logic [1:0] mode_e;
  logic req_e;

  hp_speed_sel #(.NSLOT(NSLOT), .SCAN_CYC(SCAN_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .slot_cnt(slot_cnt), .slot_closed(slot_closed),
    .m66_en(m66_en), .cap_x(cap_x), .cap_hi(cap_hi), .seg_max(seg_max),
    .bus_mode(bus_mode), .bus_rst_req(bus_rst_req), .scanning(scanning));

  always #10 clk = ~clk;

  function automatic logic [1:0] slot_dec(logic x, logic hi, logic m66);
    if (x) return hi ? 2'b11 : 2'b10;
    return m66 ? 2'b01 : 2'b00;
  endfunction

  function automatic logic [1:0] want_mode();
    logic [1:0] m = seg_max;
    for (int i = 0; i < NSLOT; i++)
      if (slot_closed[i] && i < int'(slot_cnt)) begin
        logic [1:0] s = slot_dec(cap_x[i], cap_hi[i], m66_en[i]);
        if (s < m) m = s;
      end
    return m;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check(tag, "bus_mode", int'(bus_mode), int'(mode_e));
    check(tag, "bus_rst_req", int'(bus_rst_req), int'(req_e));
    check(tag, "scanning", int'(scanning), (left > 0 && slot_cnt != 0) ? 1 : 0);
  endtask

  task automatic step(string tag);
    @(posedge clk);
    req_e = 1'b0;
    if (slot_cnt != 0) begin
      if (left > 0) left--;
      else begin
        logic [1:0] t = want_mode();
        if (t != mode_e) begin mode_e = t; req_e = 1'b1; end
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    left = SCAN_CYC; mode_e = 2'b00; req_e = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    for (int k = 0; k < SCAN_CYC - 1; k++) step("R2");
    cap_hi[2] = 1'b0;
    step("R2");
    step("R4");
    step("R6");
    slot_closed = 4'b0001; cap_x = 4'b0000; m66_en = 4'b0000;
    step("R3"); step("R3");
    m66_en = 4'b0001;
    step("R3"); step("R6");
    cap_x = 4'b0001; cap_hi = 4'b0000;
    step("R3"); step("R3");
    cap_hi = 4'b0001;
    step("R3"); step("R6");
    slot_closed = 4'b0000; seg_max = 2'b10;
    step("R5"); step("R5");
    slot_cnt = 3'd2; slot_closed = 4'b1001; cap_x = 4'b0001; cap_hi = 4'b0001;
    step("R5"); step("R5");
    slot_cnt = 3'd0; slot_closed = 4'b1111; cap_x = 4'b0000; m66_en = 4'b0000;
    step("R7"); step("R7");
    slot_cnt = 3'd4;
    step("R4"); step("R6");
    for (int k = 0; k < 400; k++) begin
      slot_cnt    = ($urandom_range(0, 5) == 0) ? 3'd0 : 3'($urandom_range(1, 4));
      slot_closed = 4'($urandom);
      m66_en      = 4'($urandom);
      cap_x       = 4'($urandom);
      cap_hi      = 4'($urandom);
      seg_max     = 2'($urandom);
      step("R4");
      if ($urandom_range(0, 2) == 0) step("R6");
    end
    finish_run();
  end
endmodule